// File: doc/BRIEF.md
# Watchdog Timer with Paired-Clear Option

This block guards a small processor against a runaway program. A counter advances on a tick enable. The tick comes either from a dedicated slow oscillator or from the instruction clock. A 3-bit select field in a local configuration register sets a power-of-two prescaler, and a terminal counter of `CNT_W` bits follows the prescaler. Software must clear the counter before it wraps. If it does not, the block asks for a full chip reset during normal running, or for a warm reset while the core is halted. The warm reset restarts only the program counter and stack pointer, and it wakes the device.

A build-time parameter picks how software clears the watchdog. One option accepts a single clear command. The other accepts only the pair of clear commands, which may arrive in either order. Two other events also clear the counter and the prescaler: the synchronous reset and entry into the halt state. The block keeps two status flags. The time-out flag shows that a wrap happened. The power-down flag shows that the halt state was entered.

Top module: `watchdog_core`

## Requirements
- R1: After a clear, `chip_rst_req` (or `warm_rst_req`) goes high at the clock edge that consumes tick number 2^ws * 2^CNT_W. It stays high for exactly one cycle.
- R2: The select field ws is `cfg_wdata[2:0]`, stored on `cfg_we`. Code 000 divides the tick by 1, and each increment doubles the ratio, up to 111 for 1:128. After reset the register holds 8'h07.
- R3: Register bits 7:3 are user flags. They read back unchanged on `cfg_rdata` and have no effect on the time-out length.
- R4: Reset, `halt_enter` or an accepted clear command zeroes both the prescaler and the terminal counter, so a full period starts again.
- R5: With `PAIRED`=0, each `clr_single` pulse is an accepted clear. `clr_first` and `clr_second` are ignored.
- R6: With `PAIRED`=1, a clear is accepted only once both `clr_first` and `clr_second` have been seen, in either order or in the same cycle. Either one alone does nothing, and `clr_single` is ignored. Both seen marks are dropped whenever the counter is cleared.
- R7: A wrap while `halted`=0 pulses `chip_rst_req` and sets `to_flag`.
- R8: A wrap while `halted`=1 pulses `warm_rst_req`, never `chip_rst_req`, and sets `to_flag`.
- R9: With `src_sel`=0 the block counts `osc_tick`, also while halted. With `src_sel`=1 it counts `instr_tick` and holds its count while `halted`=1.
- R10: Reset clears both flags. `halt_enter` sets `pd_flag` and clears `to_flag`. An accepted clear command clears both flags.
- R11: A clear in the same cycle as the terminal tick wins. No reset request follows.
- R12: After a wrap the count restarts from zero, and the next request comes one full period later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high external reset |
| osc_tick | input | 1 | Slow oscillator tick enable |
| instr_tick | input | 1 | Instruction clock tick enable |
| src_sel | input | 1 | Tick source: 0 slow oscillator, 1 instruction clock |
| halted | input | 1 | Core is in the halt state |
| halt_enter | input | 1 | Strobe: halt is being entered |
| clr_single | input | 1 | Strobe: single clear command |
| clr_first | input | 1 | Strobe: first command of the clear pair |
| clr_second | input | 1 | Strobe: second command of the clear pair |
| cfg_we | input | 1 | Configuration register write enable |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Configuration register contents |
| chip_rst_req | output | 1 | One-cycle full chip reset request |
| warm_rst_req | output | 1 | One-cycle warm reset and wake request |
| to_flag | output | 1 | Time-out status flag |
| pd_flag | output | 1 | Power-down status flag |

## Verification
A clear and the terminal tick can fall in the same cycle, and the block must decide which one wins. The bench brings the counter to one tick short of a wrap. It then asserts the clear strobes together with a tick in a single cycle, and judges from the ports that no request appears and that the next request needs a full period. A second coincidence is a lone half of the clear pair arriving while the counter runs. The two build options are driven with identical stimulus, and each one's tick count to its request is compared with the value the bench computes.

// File: rtl/wdg_pkg.sv
package wdg_pkg;

    localparam int SEL_W = 3;
    localparam int PRE_W = (1 << SEL_W) - 1;
    localparam int CFG_W = 8;

    typedef struct packed {
        logic [CFG_W-1:SEL_W] user;
        logic [SEL_W-1:0]     ws;
    } wdg_cfg_t;

    localparam wdg_cfg_t CFG_RST = '{user: '0, ws: '1};

    typedef enum logic {
        SRC_SLOW_OSC = 1'b0,
        SRC_INSTR    = 1'b1
    } wdg_src_e;

    typedef struct packed {
        logic first;
        logic second;
    } wdg_pair_t;

    // Low ws bits set: prescaler stage completes when these bits are all ones.
    function automatic logic [PRE_W-1:0] ratio_mask(input logic [SEL_W-1:0] ws);
        return ~({PRE_W{1'b1}} << ws);
    endfunction

endpackage

// File: rtl/wdg_clear_arb.sv
module wdg_clear_arb
    import wdg_pkg::*;
#(
    parameter bit PAIRED = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic halt_enter,
    input  logic clr_single,
    input  logic clr_first,
    input  logic clr_second,
    output logic cmd_clear,
    output logic wipe
);

    wdg_pair_t seen_q;
    logic      pair_done;

    assign pair_done = (seen_q.first  | clr_first) &
                       (seen_q.second | clr_second);
    assign cmd_clear = PAIRED ? pair_done : clr_single;
    assign wipe      = rst | halt_enter | cmd_clear;

    always_ff @(posedge clk) begin
        if (wipe) begin
            seen_q <= '0;
        end else begin
            if (clr_first)  seen_q.first  <= 1'b1;
            if (clr_second) seen_q.second <= 1'b1;
        end
    end

endmodule

// File: rtl/wdg_prescale.sv
module wdg_prescale
    import wdg_pkg::*;
(
    input  logic             clk,
    input  logic             wipe,
    input  logic             tick,
    input  logic [SEL_W-1:0] ws,
    output logic             stage_done
);

    logic [PRE_W-1:0] pre_q;
    logic [PRE_W-1:0] mask;

    assign mask       = ratio_mask(ws);
    assign stage_done = tick & ~wipe & ((pre_q & mask) == mask);

    always_ff @(posedge clk) begin
        if (wipe)      pre_q <= '0;
        else if (tick) pre_q <= pre_q + 1'b1;
    end

endmodule

// File: rtl/wdg_term_count.sv
module wdg_term_count #(
    parameter int CNT_W = 12
) (
    input  logic clk,
    input  logic wipe,
    input  logic step,
    input  logic halted,
    output logic fire,
    output logic chip_q,
    output logic warm_q
);

    logic [CNT_W-1:0] cnt_q;

    assign fire = step & ~wipe & (&cnt_q);

    always_ff @(posedge clk) begin
        if (wipe) begin
            cnt_q  <= '0;
            chip_q <= 1'b0;
            warm_q <= 1'b0;
        end else begin
            if (step) cnt_q <= fire ? '0 : cnt_q + 1'b1;
            chip_q <= fire & ~halted;
            warm_q <= fire &  halted;
        end
    end

endmodule

// File: rtl/watchdog_core.sv
module watchdog_core
    import wdg_pkg::*;
#(
    parameter bit PAIRED = 1'b0,
    parameter int CNT_W  = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             osc_tick,
    input  logic             instr_tick,
    input  logic             src_sel,
    input  logic             halted,
    input  logic             halt_enter,
    input  logic             clr_single,
    input  logic             clr_first,
    input  logic             clr_second,
    input  logic             cfg_we,
    input  logic [CFG_W-1:0] cfg_wdata,
    output logic [CFG_W-1:0] cfg_rdata,
    output logic             chip_rst_req,
    output logic             warm_rst_req,
    output logic             to_flag,
    output logic             pd_flag
);

    wdg_cfg_t cfg_q;
    logic     tick, cmd_clear, wipe, stage_done, fire;

    always_ff @(posedge clk) begin
        if (rst)         cfg_q <= CFG_RST;
        else if (cfg_we) cfg_q <= wdg_cfg_t'(cfg_wdata);
    end
    assign cfg_rdata = cfg_q;

    // Instruction clock is gated off while halted; the slow oscillator is not.
    assign tick = (wdg_src_e'(src_sel) == SRC_INSTR) ? (instr_tick & ~halted)
                                                      : osc_tick;

    wdg_clear_arb #(.PAIRED(PAIRED)) u_arb (
        .clk        (clk),
        .rst        (rst),
        .halt_enter (halt_enter),
        .clr_single (clr_single),
        .clr_first  (clr_first),
        .clr_second (clr_second),
        .cmd_clear  (cmd_clear),
        .wipe       (wipe)
    );

    wdg_prescale u_pre (
        .clk        (clk),
        .wipe       (wipe),
        .tick       (tick),
        .ws         (cfg_q.ws),
        .stage_done (stage_done)
    );

    wdg_term_count #(.CNT_W(CNT_W)) u_cnt (
        .clk    (clk),
        .wipe   (wipe),
        .step   (stage_done),
        .halted (halted),
        .fire   (fire),
        .chip_q (chip_rst_req),
        .warm_q (warm_rst_req)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            to_flag <= 1'b0;
            pd_flag <= 1'b0;
        end else if (halt_enter) begin
            to_flag <= 1'b0;
            pd_flag <= 1'b1;
        end else if (cmd_clear) begin
            to_flag <= 1'b0;
            pd_flag <= 1'b0;
        end else if (fire) begin
            to_flag <= 1'b1;
        end
    end

endmodule

// File: rtl/wdg_checker.sv
module wdg_checker (
    input logic clk,
    input logic rst,
    input logic halted,
    input logic halt_enter,
    input logic chip_rst_req,
    input logic warm_rst_req,
    input logic to_flag,
    input logic pd_flag
);

    AST_CHIP_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        chip_rst_req |=> !chip_rst_req); // R1

    AST_WARM_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        warm_rst_req |=> !warm_rst_req); // R1

    AST_REQ_SETS_TO: assert property (@(posedge clk) disable iff (rst)
        (chip_rst_req || warm_rst_req) |-> to_flag); // R7

    AST_REQ_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        !(chip_rst_req && warm_rst_req)); // R8

    AST_CHIP_NOT_HALTED: assert property (@(posedge clk) disable iff (rst)
        chip_rst_req |-> !$past(halted)); // R8

    AST_HALT_FLAGS: assert property (@(posedge clk) disable iff (rst)
        (halt_enter && !rst) |=> (pd_flag && !to_flag)); // R10

    AST_HALT_QUIET: assert property (@(posedge clk) disable iff (rst)
        halt_enter |=> (!chip_rst_req && !warm_rst_req)); // R11

endmodule

bind watchdog_core wdg_checker i_wdg_checker (
    .clk          (clk),
    .rst          (rst),
    .halted       (halted),
    .halt_enter   (halt_enter),
    .chip_rst_req (chip_rst_req),
    .warm_rst_req (warm_rst_req),
    .to_flag      (to_flag),
    .pd_flag      (pd_flag)
);

// File: tb/test_watchdog_core.sv
`timescale 1ns/1ps
module test_watchdog_core;

    localparam int CNT_W = 2;
    localparam int BASE  = 1 << CNT_W;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic osc_tick = 1'b0, instr_tick = 1'b0, src_sel = 1'b0, halted = 1'b0;
    logic halt_enter = 1'b0, clr_single = 1'b0, clr_first = 1'b0, clr_second = 1'b0;
    logic cfg_we = 1'b0;
    logic [7:0] cfg_wdata = 8'h00;
    logic [7:0] s_rdata, p_rdata;
    logic s_chip, s_warm, s_to, s_pd;
    logic p_chip, p_warm, p_to, p_pd;

    int checks = 0;
    int errors = 0;
    int ns, np;
    bit kw_s, kw_p;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    watchdog_core #(.PAIRED(1'b0), .CNT_W(CNT_W)) i_watchdog_core (
        .clk(clk), .rst(rst), .osc_tick(osc_tick), .instr_tick(instr_tick),
        .src_sel(src_sel), .halted(halted), .halt_enter(halt_enter),
        .clr_single(clr_single), .clr_first(clr_first), .clr_second(clr_second),
        .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_rdata(s_rdata),
        .chip_rst_req(s_chip), .warm_rst_req(s_warm), .to_flag(s_to), .pd_flag(s_pd)
    );

    watchdog_core #(.PAIRED(1'b1), .CNT_W(CNT_W)) i_watchdog_core_pair (
        .clk(clk), .rst(rst), .osc_tick(osc_tick), .instr_tick(instr_tick),
        .src_sel(src_sel), .halted(halted), .halt_enter(halt_enter),
        .clr_single(clr_single), .clr_first(clr_first), .clr_second(clr_second),
        .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_rdata(p_rdata),
        .chip_rst_req(p_chip), .warm_rst_req(p_warm), .to_flag(p_to), .pd_flag(p_pd)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic step();
        osc_tick = 1'b1; instr_tick = 1'b1;
        @(negedge clk);
        osc_tick = 1'b0; instr_tick = 1'b0;
    endtask

    task automatic steps(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic strobe(input bit s, input bit f, input bit sc, input bit h);
        clr_single = s; clr_first = f; clr_second = sc; halt_enter = h;
        @(negedge clk);
        clr_single = 1'b0; clr_first = 1'b0; clr_second = 1'b0; halt_enter = 1'b0;
    endtask

    task automatic full_clear();
        strobe(1'b1, 1'b1, 1'b1, 1'b0);
    endtask

    task automatic write_cfg(input logic [7:0] v);
        cfg_we = 1'b1; cfg_wdata = v;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // Ticks until each instance requests a reset; -1 if none within limit.
    task automatic measure(input int limit);
        ns = -1; np = -1;
        for (int n = 1; n <= limit && (ns < 0 || np < 0); n++) begin
            step();
            if (ns < 0 && (s_chip || s_warm)) begin ns = n; kw_s = s_warm; end
            if (np < 0 && (p_chip || p_warm)) begin np = n; kw_p = p_warm; end
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // Reset state (R2, R10)
        chk("R2 reset cfg", int'(s_rdata), 8'h07);
        chk("R10 reset to", int'(s_to | p_to), 0);
        chk("R10 reset pd", int'(s_pd | p_pd), 0);
        chk("R7 reset req", int'(s_chip | s_warm | p_chip | p_warm), 0);

        // Sweep every ratio with several user-flag patterns (R1, R2, R3, R7, R12)
        for (int ws = 0; ws < 8; ws++) begin
            for (int u = 0; u < 3; u++) begin
                logic [4:0] ub;
                logic [7:0] v;
                int per;
                ub = (u == 0) ? 5'h00 : (u == 1) ? 5'h1F : 5'h15;
                v = {ub, 3'(ws)};
                per = (1 << ws) * BASE;
                write_cfg(v);
                chk("R3 user bits readback", int'(s_rdata), int'(v));
                full_clear();
                measure(per + 4);
                chk("R1 R2 R3 period single", ns, per);
                chk("R1 R2 R3 period paired", np, per);
                chk("R7 chip kind", int'(kw_s | kw_p), 0);
                chk("R7 to set", int'(s_to & p_to), 1);
                measure(per + 4);
                chk("R12 second period single", ns, per);
                chk("R12 second period paired", np, per);
            end
        end

        write_cfg(8'h00);

        // Single clear mid-count: accepted only by single option (R4, R5, R6)
        full_clear(); steps(3); strobe(1'b1, 1'b0, 1'b0, 1'b0);
        measure(20);
        chk("R5 single clear restarts", ns, BASE);
        chk("R6 single clear ignored by pair", np, 1);

        // Pair in reverse order clears paired option only (R5, R6)
        full_clear(); step(); strobe(1'b0, 1'b0, 1'b1, 1'b0);
        step(); strobe(1'b0, 1'b1, 1'b0, 1'b0);
        measure(20);
        chk("R6 reverse pair clears", np, BASE);
        chk("R5 pair strobes ignored", ns, BASE - 2);

        // Lone first command has no effect (R6)
        full_clear(); steps(2); strobe(1'b0, 1'b1, 1'b0, 1'b0);
        measure(20);
        chk("R6 lone first no effect", np, BASE - 2);
        chk("R5 lone first single", ns, BASE - 2);

        // Seen marks dropped after clear (R6)
        full_clear(); step(); strobe(1'b0, 1'b1, 1'b0, 1'b0);
        step(); strobe(1'b0, 1'b0, 1'b1, 1'b0);
        step(); strobe(1'b0, 1'b0, 1'b1, 1'b0);
        measure(20);
        chk("R6 marks dropped", np, BASE - 1);
        chk("R5 marks single", ns, 1);

        // Clear coincides with terminal tick (R11, R4)
        full_clear(); steps(BASE - 1);
        osc_tick = 1'b1; instr_tick = 1'b1;
        clr_single = 1'b1; clr_first = 1'b1; clr_second = 1'b1;
        @(negedge clk);
        osc_tick = 1'b0; instr_tick = 1'b0;
        clr_single = 1'b0; clr_first = 1'b0; clr_second = 1'b0;
        chk("R11 no request on coincident clear", int'(s_chip | s_warm | p_chip | p_warm), 0);
        measure(20);
        chk("R11 full period after single", ns, BASE);
        chk("R11 full period after pair", np, BASE);

        // Halt entry, slow oscillator keeps counting, warm request (R4, R8, R9, R10)
        src_sel = 1'b0;
        full_clear(); steps(2);
        halted = 1'b1;
        strobe(1'b0, 1'b0, 1'b0, 1'b1);
        chk("R10 halt sets pd", int'(s_pd & p_pd), 1);
        chk("R10 halt clears to", int'(s_to | p_to), 0);
        measure(20);
        chk("R4 halt restarts single", ns, BASE);
        chk("R4 halt restarts paired", np, BASE);
        chk("R8 warm kind", int'(kw_s & kw_p), 1);
        chk("R8 to set", int'(s_to & p_to), 1);

        // Instruction clock stops in halt (R9)
        src_sel = 1'b1;
        full_clear();
        begin
            int seen;
            seen = 0;
            for (int i = 0; i < 20; i++) begin
                step();
                if (s_chip | s_warm | p_chip | p_warm) seen++;
            end
            chk("R9 frozen in halt", seen, 0);
        end
        halted = 1'b0;
        measure(20);
        chk("R9 instr count single", ns, BASE);
        chk("R9 instr count paired", np, BASE);
        chk("R7 instr chip kind", int'(kw_s | kw_p), 0);

        // Clear commands clear flags (R10)
        src_sel = 1'b0;
        strobe(1'b0, 1'b0, 1'b0, 1'b1);
        strobe(1'b1, 1'b0, 1'b0, 1'b0);
        chk("R10 single clears pd", int'(s_pd), 0);
        chk("R10 single ignored by pair pd", int'(p_pd), 1);
        strobe(1'b0, 1'b1, 1'b1, 1'b0);
        chk("R10 pair clears pd", int'(p_pd), 0);
        measure(20);
        strobe(1'b1, 1'b0, 1'b0, 1'b0);
        chk("R10 single clears to", int'(s_to), 0);
        chk("R10 pair keeps to", int'(p_to), 1);
        strobe(1'b0, 1'b1, 1'b1, 1'b0);
        chk("R10 pair clears to", int'(p_to), 0);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule